// File: doc/BRIEF.md
# Host-to-DSP Transmit Buffer Front End

This block sits between a host bus and a DSP-side consumer. It takes host write accesses, decides whether each access addresses the transmit buffer, packs the host data into a 24-bit word and stores the word in a small FIFO. The DSP side drains the FIFO through a valid/ready handshake.

There are two host address decoders. The first is a PCI-style memory window. The second is a generic microprocessor bus, where the buffer sits at one register slot behind an 8-bit base compare. When the buffer is full, the block stalls the host. On the PCI side the stall is bounded, after which the access is refused with a retry. On the generic bus the host waits until a slot frees up. Two outputs tell the DSP-side software that the buffer has room: a request status flag, and either an interrupt or a DMA request.

Top module: `hostx_txbuf`

## Requirements
- R1: With `cfg_generic`=0, a write hits the buffer only when `h_addr[31:16]` equals `cfg_pci_base`, `h_addr[1:0]`=0, and `h_addr[15:0]` lies in 0x001C..0xFFFC inclusive. A write outside this window gets neither `h_ack` nor `h_retry`.
- R2: With `cfg_generic`=1, a write hits only when `h_addr[10:3]` equals `cfg_gen_base` and `h_addr[2:0]`=3'b111.
- R3: The stored word depends on `cfg_fmt`, the same way in both bus modes. Value 0 stores `h_data[23:0]`. Value 1 stores `{h_data[15:0],8'h00}`. Values 2 and 3 store `{8'h00,h_data[15:0]}`.
- R4: `h_be` has no effect on the stored word.
- R5: Words reach `dsp_data` in write order. A word leaves the FIFO on a clock edge where `dsp_valid` and `dsp_ready` are both 1. The default depth is 2. `tx_ready` is 1 exactly when the FIFO is not full.
- R6: `req_stat` = `tx_ready` AND `cfg_treq_en`. While `req_stat` is 1, `irq` is 1 if `cfg_dma_en`=0, and `dma_req` is 1 if `cfg_dma_en`=1. Otherwise both are 0.
- R7: A hit write is acknowledged (`h_ack`=1, word stored) in the first cycle the FIFO is not full. In PCI mode with `cfg_wait_dis`=0, up to 8 wait cycles are inserted first.
- R8: In PCI mode with `cfg_wait_dis`=0, if the FIFO is still full after 8 wait cycles, the next cycle gives `h_retry`=1 and the word is dropped.
- R9: In generic mode, a write to a full FIFO waits as long as needed and never gets `h_retry`.
- R10: In PCI mode with `cfg_wait_dis`=1, a write to a full FIFO gets `h_retry` in its first cycle and the word is dropped.
- R11: `rst_n`=0, `soft_rst`=1 or `soft_rst_pers`=1 at a clock edge empties the FIFO. The next cycle shows `tx_ready`=1 and `dsp_valid`=0.
- R12: A write and a pop in the same cycle, with the FIFO not full, both take effect and leave the fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| soft_rst | input | 1 | Software reset, empties buffer |
| soft_rst_pers | input | 1 | Second software reset kind, empties buffer |
| cfg_generic | input | 1 | 0 = PCI window decode, 1 = generic bus decode |
| cfg_fmt | input | 2 | Byte placement select |
| cfg_wait_dis | input | 1 | PCI: refuse at once instead of waiting |
| cfg_treq_en | input | 1 | Enables the room request |
| cfg_dma_en | input | 1 | Routes the request to dma_req instead of irq |
| cfg_pci_base | input | 16 | Upper address bits of the PCI window |
| cfg_gen_base | input | 8 | Generic bus base compare value |
| h_wr | input | 1 | Host write request, held until ack or retry |
| h_addr | input | 32 | Host address |
| h_data | input | 32 | Host write data |
| h_be | input | 4 | Host byte enables (ignored) |
| h_ack | output | 1 | Write accepted this cycle |
| h_retry | output | 1 | Write refused this cycle |
| tx_ready | output | 1 | Buffer has room |
| req_stat | output | 1 | Request status flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| dsp_valid | output | 1 | Head word available |
| dsp_data | output | 24 | Head word |
| dsp_ready | input | 1 | DSP side takes the head word |

## Verification
A host write and a DSP-side pop can meet in one cycle. The bench provokes this in two ways. With one word held, a forked thread raises `dsp_ready` on the same edge where the write is acknowledged. The bench then checks that `tx_ready` stays 1 and that exactly one more write fills the buffer. With the buffer full, the pop is timed against a stalled write. The bench then checks the exact number of wait cycles before the acknowledge. In both cases the scoreboard confirms the order of the delivered words.

// File: rtl/hostx_pkg.sv
`timescale 1ns/1ps
// hostx_pkg: shared word width and byte-placement codes for the transmit buffer.
// Assumes a 24-bit DSP word; all modules import from here.
package hostx_pkg;
    localparam int WORD_W = 24;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        FMT_FULL24 = 2'd0,
        FMT_HIGH16 = 2'd1,
        FMT_LOW16  = 2'd2,
        FMT_LOW16B = 2'd3
    } fmt_e;
endpackage

// File: rtl/hostx_decode.sv
`timescale 1ns/1ps
// hostx_decode: decides whether the current host address selects the buffer.
// Assumes the PCI window is aligned on a 64 KiB boundary given by pci_base.
module hostx_decode #(
    parameter logic [15:0] WIN_LO  = 16'h001C,
    parameter logic [15:0] WIN_HI  = 16'hFFFC,
    parameter int          GBASE_W = 8
) (
    input  logic               gen_mode,
    input  logic [31:0]        addr,
    input  logic [15:0]        pci_base,
    input  logic [GBASE_W-1:0] gen_base,
    output logic               hit
);
    logic [15:0] offs;
    logic        pci_hit;
    logic        gen_hit;

    // Window and slot compares for both decoders.
    always_comb begin
        offs    = addr[15:0];
        pci_hit = (addr[31:16] == pci_base) && (offs[1:0] == 2'b00)
                  && (offs >= WIN_LO) && (offs <= WIN_HI);
        gen_hit = (addr[3 +: GBASE_W] == gen_base) && (addr[2:0] == 3'b111);
        hit     = gen_mode ? gen_hit : pci_hit;
    end
endmodule

// File: rtl/hostx_pack.sv
`timescale 1ns/1ps
// hostx_pack: places host data bytes into the 24-bit word by format code.
// Assumes byte enables play no part; unused bytes are zero.
module hostx_pack
    import hostx_pkg::*;
(
    input  logic [1:0]  fmt,
    input  logic [23:0] din,
    output word_t       word
);
    // Byte placement selected by the format code.
    always_comb begin
        unique case (fmt_e'(fmt))
            FMT_FULL24: word = din;
            FMT_HIGH16: word = {din[15:0], 8'h00};
            default:    word = {8'h00, din[15:0]};
        endcase
    end
endmodule

// File: rtl/hostx_fifo.sv
`timescale 1ns/1ps
// hostx_fifo: circular word store drained through valid/ready.
// Assumes push is only raised when full is low; clr empties it synchronously.
module hostx_fifo
    import hostx_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  word_t         wdata,
    input  logic          pop_rdy,
    output logic          valid,
    output word_t         rdata,
    output logic          full,
    output logic [CW-1:0] fill
);
    word_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Status derived from the fill level.
    always_comb begin
        valid  = (fill != '0);
        full   = (fill == CW'(DEPTH));
        do_pop = pop_rdy && valid;
        rdata  = mem[rd_ptr];
    end

    // Pointer and fill-level update with reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push)   wr_ptr <= bump(wr_ptr);
            if (do_pop) rd_ptr <= bump(rd_ptr);
            if (push && !do_pop)      fill <= fill + 1'b1;
            else if (!push && do_pop) fill <= fill - 1'b1;
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/hostx_stall.sv
`timescale 1ns/1ps
// hostx_stall: answers a decoded host write with ack, wait or retry.
// Assumes the host holds its request until ack or retry, then drops it.
module hostx_stall #(
    parameter int MAX_WAIT = 8,
    localparam int NW = $clog2(MAX_WAIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic req,
    input  logic full,
    input  logic gen_mode,
    input  logic wait_dis,
    output logic ack,
    output logic retry
);
    logic [NW-1:0] wcnt;

    // Response for the current cycle.
    always_comb begin
        ack   = req && !full;
        retry = 1'b0;
        if (req && full && !gen_mode)
            retry = wait_dis || (wcnt == NW'(MAX_WAIT));
    end

    // Counts wait cycles of the pending PCI write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !req || ack || retry)
            wcnt <= '0;
        else if (full && !gen_mode)
            wcnt <= wcnt + 1'b1;
    end
endmodule

// File: rtl/hostx_txbuf.sv
`timescale 1ns/1ps
// hostx_txbuf: top of the host-to-DSP transmit buffer front end.
// Assumes configuration inputs are quasi-static while a write is pending.
module hostx_txbuf
    import hostx_pkg::*;
#(
    parameter int DEPTH    = 2,
    parameter int MAX_WAIT = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        soft_rst_pers,
    input  logic        cfg_generic,
    input  logic [1:0]  cfg_fmt,
    input  logic        cfg_wait_dis,
    input  logic        cfg_treq_en,
    input  logic        cfg_dma_en,
    input  logic [15:0] cfg_pci_base,
    input  logic [7:0]  cfg_gen_base,
    input  logic        h_wr,
    input  logic [31:0] h_addr,
    input  logic [31:0] h_data,
    input  logic [3:0]  h_be,
    output logic        h_ack,
    output logic        h_retry,
    output logic        tx_ready,
    output logic        req_stat,
    output logic        irq,
    output logic        dma_req,
    output logic        dsp_valid,
    output logic [23:0] dsp_data,
    input  logic        dsp_ready
);
    logic          addr_hit;
    logic          req_hit;
    logic          full;
    logic          clr;
    word_t         packed_w;
    logic [CW-1:0] fill;
    logic          unused_bits;

    // Byte enables and top data byte do not reach the buffer.
    assign unused_bits = ^{h_be, h_data[31:24]};

    // Request qualification, software clear and room signalling.
    always_comb begin
        clr      = soft_rst || soft_rst_pers;
        req_hit  = h_wr && addr_hit;
        tx_ready = !full;
        req_stat = tx_ready && cfg_treq_en;
        irq      = req_stat && !cfg_dma_en;
        dma_req  = req_stat && cfg_dma_en;
    end

    hostx_decode #(.WIN_LO(16'h001C), .WIN_HI(16'hFFFC), .GBASE_W(8)) i_decode (
        .gen_mode (cfg_generic),
        .addr     (h_addr),
        .pci_base (cfg_pci_base),
        .gen_base (cfg_gen_base),
        .hit      (addr_hit)
    );

    hostx_pack i_pack (
        .fmt  (cfg_fmt),
        .din  (h_data[23:0]),
        .word (packed_w)
    );

    hostx_stall #(.MAX_WAIT(MAX_WAIT)) i_stall (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .req      (req_hit),
        .full     (full),
        .gen_mode (cfg_generic),
        .wait_dis (cfg_wait_dis),
        .ack      (h_ack),
        .retry    (h_retry)
    );

    hostx_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .push    (h_ack),
        .wdata   (packed_w),
        .pop_rdy (dsp_ready),
        .valid   (dsp_valid),
        .rdata   (dsp_data),
        .full    (full),
        .fill    (fill)
    );
endmodule

// File: rtl/hostx_txbuf_chk.sv
`timescale 1ns/1ps
// hostx_txbuf_chk: property checker bound to hostx_txbuf.
// Assumes it sees the top's ports plus the decoded request and fill level.
module hostx_txbuf_chk #(
    parameter int DEPTH    = 2,
    parameter int MAX_WAIT = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int SW = $clog2(MAX_WAIT + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          soft_rst_pers,
    input logic          cfg_generic,
    input logic          cfg_wait_dis,
    input logic          req_hit,
    input logic          h_ack,
    input logic          h_retry,
    input logic          tx_ready,
    input logic          irq,
    input logic          dma_req,
    input logic          dsp_valid,
    input logic          dsp_ready,
    input logic [CW-1:0] fill
);
    logic [SW-1:0] scnt;

    // Independent count of PCI stall cycles of the pending write.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_hit || h_ack || h_retry || soft_rst || soft_rst_pers)
            scnt <= '0;
        else if (!cfg_generic && !tx_ready)
            scnt <= scnt + 1'b1;
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    p_push_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ack && !(dsp_valid && dsp_ready) && !soft_rst && !soft_rst_pers)
        |=> (fill == $past(fill) + CW'(1)));

    p_irq_dma_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && dma_req));

    p_ack_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        h_ack |-> tx_ready);

    p_retry_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_retry && !cfg_generic && !cfg_wait_dis) |-> (scnt == SW'(MAX_WAIT)));

    p_generic_no_retry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_generic |-> !h_retry);

    p_fast_retry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (h_retry && cfg_wait_dis) |-> (scnt == '0));

    p_soft_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst || soft_rst_pers) |=> (tx_ready && !dsp_valid));

    p_ack_retry_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_ack && h_retry));
endmodule

bind hostx_txbuf hostx_txbuf_chk #(.DEPTH(DEPTH), .MAX_WAIT(MAX_WAIT)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .soft_rst_pers (soft_rst_pers),
    .cfg_generic   (cfg_generic),
    .cfg_wait_dis  (cfg_wait_dis),
    .req_hit       (req_hit),
    .h_ack         (h_ack),
    .h_retry       (h_retry),
    .tx_ready      (tx_ready),
    .irq           (irq),
    .dma_req       (dma_req),
    .dsp_valid     (dsp_valid),
    .dsp_ready     (dsp_ready),
    .fill          (fill)
);

// File: tb/test_hostx_txbuf.sv
`timescale 1ns/1ps
// test_hostx_txbuf: scoreboard bench; driver queues expected words, monitor compares pops.
module test_hostx_txbuf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        soft_rst_pers = 1'b0;
    logic        cfg_generic = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic        cfg_wait_dis = 1'b0;
    logic        cfg_treq_en = 1'b0;
    logic        cfg_dma_en = 1'b0;
    logic [15:0] cfg_pci_base = 16'h8A00;
    logic [7:0]  cfg_gen_base = 8'h5C;
    logic        h_wr = 1'b0;
    logic [31:0] h_addr = '0;
    logic [31:0] h_data = '0;
    logic [3:0]  h_be = 4'hF;
    logic        h_ack, h_retry, tx_ready, req_stat, irq, dma_req, dsp_valid;
    logic [23:0] dsp_data;
    logic        dsp_ready = 1'b0;

    int          checks = 0;
    int          errors = 0;
    logic [23:0] exp_q[$];
    logic [23:0] exp_w;
    int          res, waits;

    always #2 clk = ~clk;

    hostx_txbuf i_hostx_txbuf (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [23:0] pack(input logic [1:0] f, input logic [31:0] d);
        if (f == 2'd0)      return d[23:0];
        else if (f == 2'd1) return {d[15:0], 8'h00};
        else                return {8'h00, d[15:0]};
    endfunction

    function automatic logic [31:0] pci_a(input logic [15:0] off);
        return {cfg_pci_base, off};
    endfunction

    function automatic logic [31:0] gen_a(input logic [7:0] b, input logic [2:0] s);
        return {21'h1A5A5, b, s};
    endfunction

    // Driver: one host write; res 0=ack 1=retry 2=none within limit.
    task automatic host_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                              input int limit, output int r, output int w);
        @(negedge clk);
        h_addr = a; h_data = d; h_be = be; h_wr = 1'b1;
        r = 2; w = 0;
        for (int i = 0; i < limit; i++) begin
            #1;
            if (h_ack) begin r = 0; exp_q.push_back(pack(cfg_fmt, d)); break; end
            if (h_retry) begin r = 1; break; end
            w++;
            @(negedge clk);
        end
        if (r != 2) @(negedge clk);
        h_wr = 1'b0;
    endtask

    // Monitor: compares every popped word with the scoreboard head.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !soft_rst && !soft_rst_pers && dsp_valid && dsp_ready) begin
            if (exp_q.size() == 0) chk(1'b0, "R5 unexpected word", dsp_data, 0);
            else begin
                exp_w = exp_q.pop_front();
                chk(dsp_data == exp_w, "R5 R3 order/data", dsp_data, exp_w);
            end
        end
    end

    task automatic drain_idle();
        dsp_ready = 1'b1;
        repeat (4) @(negedge clk);
        #1 chk(exp_q.size() == 0, "R5 all words delivered", exp_q.size(), 0);
        chk(dsp_valid == 1'b0, "R5 empty after drain", dsp_valid, 0);
    endtask

    task automatic fill_two(input logic [31:0] d0, input logic [31:0] d1);
        dsp_ready = 1'b0;
        host_write(cfg_generic ? gen_a(cfg_gen_base, 3'd7) : pci_a(16'h0040), d0, 4'hF, 4, res, waits);
        host_write(cfg_generic ? gen_a(cfg_gen_base, 3'd7) : pci_a(16'h0040), d1, 4'hF, 4, res, waits);
        #1 chk(tx_ready == 1'b0, "R5 full after two words", tx_ready, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R5 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(tx_ready == 1'b1, "R11 reset tx_ready", tx_ready, 1);
        chk(dsp_valid == 1'b0, "R11 reset empty", dsp_valid, 0);
        chk(req_stat == 1'b0 && irq == 1'b0, "R6 disabled request", {req_stat, irq}, 0);

        // R6 routing
        cfg_treq_en = 1'b1; #1;
        chk(req_stat && irq && !dma_req, "R6 irq route", {req_stat, irq, dma_req}, 3'b110);
        cfg_dma_en = 1'b1; #1;
        chk(req_stat && !irq && dma_req, "R6 dma route", {req_stat, irq, dma_req}, 3'b101);
        cfg_dma_en = 1'b0;

        // R1 window, R3 formats, R4 byte enables
        dsp_ready = 1'b1;
        host_write(pci_a(16'h001C), 32'hFFA1B2C3, 4'hF, 4, res, waits);
        chk(res == 0, "R1 low edge hit", res, 0);
        host_write(pci_a(16'hFFFC), 32'h00123456, 4'h0, 4, res, waits);
        chk(res == 0, "R1 R4 high edge hit, no byte enables", res, 0);
        host_write(pci_a(16'h0018), 32'h111111, 4'hF, 4, res, waits);
        chk(res == 2 && waits == 4, "R1 below window ignored", res, 2);
        host_write(pci_a(16'h0021), 32'h222222, 4'hF, 4, res, waits);
        chk(res == 2, "R1 misaligned ignored", res, 2);
        host_write({16'h8A01, 16'h0040}, 32'h333333, 4'hF, 4, res, waits);
        chk(res == 2, "R1 other base ignored", res, 2);
        cfg_fmt = 2'd1;
        host_write(pci_a(16'h0100), 32'h00CAFE77, 4'h1, 4, res, waits);
        chk(res == 0, "R3 pci high16", res, 0);
        cfg_fmt = 2'd2;
        host_write(pci_a(16'h0104), 32'h00BEEF12, 4'h8, 4, res, waits);
        chk(res == 0, "R3 pci low16", res, 0);
        drain_idle();

        // R2 generic decode, R3 formats
        cfg_generic = 1'b1; cfg_fmt = 2'd0;
        host_write(gen_a(8'h5C, 3'd7), 32'h00ABCDEF, 4'hF, 4, res, waits);
        chk(res == 0, "R2 slot hit", res, 0);
        host_write(gen_a(8'h5C, 3'd6), 32'h00444444, 4'hF, 4, res, waits);
        chk(res == 2, "R2 other slot ignored", res, 2);
        host_write(gen_a(8'h5D, 3'd7), 32'h00555555, 4'hF, 4, res, waits);
        chk(res == 2, "R2 other base ignored", res, 2);
        cfg_fmt = 2'd1;
        host_write(gen_a(8'h5C, 3'd7), 32'h00009876, 4'hF, 4, res, waits);
        chk(res == 0, "R3 generic high16", res, 0);
        cfg_fmt = 2'd3;
        host_write(gen_a(8'h5C, 3'd7), 32'h00FF5432, 4'hF, 4, res, waits);
        chk(res == 0, "R3 generic low16 code 3", res, 0);
        drain_idle();

        // R9 generic unbounded wait
        cfg_fmt = 2'd0;
        fill_two(32'h010101, 32'h020202);
        #1 chk(req_stat == 1'b0 && irq == 1'b0, "R6 no request when full", {req_stat, irq}, 0);
        fork
            host_write(gen_a(8'h5C, 3'd7), 32'h030303, 4'hF, 40, res, waits);
            begin
                repeat (12) @(negedge clk);
                dsp_ready = 1'b1;
                @(negedge clk);
                dsp_ready = 1'b0;
            end
        join
        chk(res == 0 && waits == 12, "R9 long wait then ack", waits, 12);
        drain_idle();

        // R7 PCI bounded wait satisfied in time
        cfg_generic = 1'b0;
        fill_two(32'h0A0A0A, 32'h0B0B0B);
        fork
            host_write(pci_a(16'h0040), 32'h0C0C0C, 4'hF, 20, res, waits);
            begin
                repeat (3) @(negedge clk);
                dsp_ready = 1'b1;
                @(negedge clk);
                dsp_ready = 1'b0;
            end
        join
        chk(res == 0 && waits == 3, "R7 ack after pop", waits, 3);

        // R8 PCI retry after eight waits
        #1 chk(tx_ready == 1'b0, "R5 full again", tx_ready, 0);
        host_write(pci_a(16'h0040), 32'h0D0D0D, 4'hF, 20, res, waits);
        chk(res == 1, "R8 retry given", res, 1);
        chk(waits == 8, "R8 eight waits", waits, 8);

        // R10 immediate retry
        cfg_wait_dis = 1'b1;
        host_write(pci_a(16'h0040), 32'h0E0E0E, 4'hF, 20, res, waits);
        chk(res == 1 && waits == 0, "R10 immediate retry", waits, 0);
        cfg_wait_dis = 1'b0;
        drain_idle();

        // R12 push and pop in one cycle
        dsp_ready = 1'b0;
        host_write(pci_a(16'h0200), 32'h121212, 4'hF, 4, res, waits);
        fork
            host_write(pci_a(16'h0200), 32'h343434, 4'hF, 4, res, waits);
            begin
                @(negedge clk);
                dsp_ready = 1'b1;
                @(negedge clk);
                dsp_ready = 1'b0;
            end
        join
        #1 chk(tx_ready == 1'b1 && dsp_valid == 1'b1, "R12 level kept at one", {tx_ready, dsp_valid}, 2'b11);
        host_write(pci_a(16'h0200), 32'h565656, 4'hF, 4, res, waits);
        #1 chk(tx_ready == 1'b0, "R12 one more write fills", tx_ready, 0);
        drain_idle();

        // R11 software resets and hardware reset
        fill_two(32'h777777, 32'h888888);
        @(negedge clk); soft_rst = 1'b1; exp_q.delete();
        @(negedge clk); soft_rst = 1'b0;
        #1 chk(tx_ready && !dsp_valid, "R11 soft reset empties", {tx_ready, dsp_valid}, 2'b10);
        fill_two(32'h999999, 32'hAAAAAA);
        @(negedge clk); soft_rst_pers = 1'b1; exp_q.delete();
        @(negedge clk); soft_rst_pers = 1'b0;
        #1 chk(tx_ready && !dsp_valid, "R11 second soft reset empties", {tx_ready, dsp_valid}, 2'b10);
        fill_two(32'hBBBBBB, 32'hCCCCCC);
        @(negedge clk); rst_n = 1'b0; exp_q.delete();
        @(negedge clk); rst_n = 1'b1;
        #1 chk(tx_ready && !dsp_valid, "R11 hardware reset empties", {tx_ready, dsp_valid}, 2'b10);
        drain_idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule